// File: doc/BRIEF.md
# ECC-Corrected Dirty Line Write-Back Unit

This unit takes a dirty data-cache line that has been chosen for eviction and writes it to external memory as one write burst. The line comes in one protected word per cycle. Each 32-bit word carries a 7-bit single-error-correct, double-error-detect code. The request that starts the eviction also carries two flags: one for an uncorrectable error in the tag storage and one for an uncorrectable error in the dirty-bit storage. The unit corrects single-bit errors before the data leaves. A word with an uncorrectable error goes out with every byte strobe cleared. If either metadata flag is set, the whole write-back is dropped.

At the end of every eviction it accepts, the unit gives a one-cycle completion pulse, even when it sent no beats, so the linefill that follows can go ahead. In the same cycle it reports an imprecise-abort request and a cause vector. When the cache runs in parity mode, lines are always written through and cannot be dirty, so eviction requests are ignored. Stores to write-through regions that met a cache write error are sent out on the same write channel as single beats, so their data is not lost.

Top module: `evict_writer`

## Requirements
- R1: An accepted eviction with no errors sends 8 beats. Beat i goes to the line-aligned base address plus 4*i and carries the original word with strobes 4'hF. Only beat 7 has last=1. After the last beat is accepted, ev_done pulses for exactly one cycle. After reset, bus_valid, ev_done and abort_req are all low.
- R2: A word with one flipped data bit is sent corrected, with strobes 4'hF. abort_cause bit 2 is set at completion. abort_req rises only if ce_abort_en is high.
- R3: A word with two flipped bits is sent with strobes 4'h0, and every other word of the line is still sent normally. abort_cause bit 1 is set and abort_req is raised at completion. Beats of an eviction carry strobes that are either all set or all clear.
- R4: If ev_tag_ue or ev_dirty_ue is set on the request, the unit still takes in the line's 8 words but sends no beats. It then pulses ev_done with abort_req high and abort_cause bit 0 set.
- R5: While parity_mode is high, ev_req and the words that follow it are ignored: no beats, no ev_done and no abort.
- R6: While bus_valid is high and bus_ready is low, bus_valid stays high and address, data, strobes and last do not change.
- R7: A write-through store is taken in when wt_valid and wt_ready are both high. It is sent as one beat with its own address, data and strobes, and last=1. wt_ready is low whenever an eviction is being collected, is waiting to be sent, is being sent, or is being requested in the same cycle.
- R8: abort_req is high only in a cycle where ev_done is high, and it lasts one cycle. abort_cause is {correctable seen, data uncorrectable seen, metadata uncorrectable}.
- R9: A flip in one of the check bits counts as correctable: the data goes out unchanged with strobes 4'hF, and abort_cause bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| parity_mode | input | 1 | Cache in parity mode; eviction requests ignored |
| ce_abort_en | input | 1 | Correctable errors also request an abort |
| ev_req | input | 1 | Start of a line eviction (one cycle) |
| ev_addr | input | ADDR_W | Line address (low offset bits ignored) |
| ev_tag_ue | input | 1 | Uncorrectable tag error for this line |
| ev_dirty_ue | input | 1 | Uncorrectable dirty-bit error for this line |
| wd_valid | input | 1 | Line word present (from the cycle after ev_req) |
| wd_data | input | 32 | Line word data |
| wd_ecc | input | 7 | Line word check code |
| wt_valid | input | 1 | Write-through store offered |
| wt_ready | output | 1 | Write-through store taken |
| wt_addr | input | ADDR_W | Store address |
| wt_data | input | 32 | Store data |
| wt_strb | input | 4 | Store byte strobes |
| bus_valid | output | 1 | Write beat valid |
| bus_ready | input | 1 | Memory accepts beat |
| bus_addr | output | ADDR_W | Beat address |
| bus_data | output | 32 | Beat data |
| bus_strb | output | 4 | Beat byte strobes |
| bus_last | output | 1 | Final beat of burst |
| ev_done | output | 1 | Eviction finished (one cycle) |
| abort_req | output | 1 | Imprecise abort request |
| abort_cause | output | 3 | {correctable, data uncorrectable, metadata uncorrectable} |

## Verification
A write-through store and an eviction request can reach the unit in the same cycle. The bench provokes this by raising wt_valid and ev_req on the same edge, and judges it by the scoreboard order: all eight eviction beats must come out before the store beat, and the store must not be taken until completion has pulsed. The reverse overlap is also driven. A store is taken while bus_ready is held low, and an eviction is then requested and filled during the stall. The bench checks that the stalled store beat stays stable on the bus, and that it comes out ahead of the burst once ready returns.

// File: rtl/evw_pkg.sv
package evw_pkg;

    localparam int EVW_DW = 32;
    localparam int EVW_SW = 6;
    localparam int EVW_CW = EVW_SW + 1;

    typedef enum logic [1:0] {
        SND_IDLE = 2'd0,
        SND_WT   = 2'd1,
        SND_EV   = 2'd2,
        SND_DONE = 2'd3
    } evw_snd_e;

    // Column code of data bit idx: the idx-th value that is not a power of two.
    function automatic logic [EVW_SW-1:0] evw_col(input int idx);
        int n;
        logic [EVW_SW-1:0] r;
        n = 0;
        r = '0;
        for (int v = 3; v < (1 << EVW_SW); v++) begin
            if ((v & (v - 1)) != 0) begin
                if (n == idx) r = v[EVW_SW-1:0];
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [EVW_CW-1:0] evw_encode(input logic [EVW_DW-1:0] d);
        logic [EVW_CW-1:0] c;
        logic [EVW_SW-1:0] s;
        c = '0;
        for (int i = 0; i < EVW_DW; i++) begin
            s = evw_col(i);
            for (int k = 0; k < EVW_SW; k++) begin
                if (s[k]) c[k] = c[k] ^ d[i];
            end
        end
        c[EVW_CW-1] = (^d) ^ (^c[EVW_SW-1:0]);
        return c;
    endfunction

endpackage

// File: rtl/evw_secded_dec.sv
module evw_secded_dec
    import evw_pkg::*;
(
    input  logic [EVW_DW-1:0] raw_data,
    input  logic [EVW_CW-1:0] raw_chk,
    output logic [EVW_DW-1:0] fix_data,
    output logic              corr_err,
    output logic              uncorr_err
);

    logic [EVW_CW-1:0] recomputed;
    logic [EVW_SW-1:0] syn;
    logic              ovr;
    logic              hit;

    assign recomputed = evw_encode(raw_data);
    assign syn        = recomputed[EVW_SW-1:0] ^ raw_chk[EVW_SW-1:0];
    assign ovr        = ^{raw_data, raw_chk};

    always_comb begin
        fix_data   = raw_data;
        corr_err   = 1'b0;
        uncorr_err = 1'b0;
        hit        = 1'b0;
        for (int i = 0; i < EVW_DW; i++) begin
            if (ovr && (syn == evw_col(i))) begin
                fix_data[i] = ~raw_data[i];
                hit         = 1'b1;
            end
        end
        if (ovr) begin
            if ((syn == '0) || $onehot(syn) || hit) corr_err = 1'b1;
            else                                    uncorr_err = 1'b1;
        end else if (syn != '0) begin
            uncorr_err = 1'b1;
        end
    end

endmodule

// File: rtl/evw_line_buf.sv
module evw_line_buf #(
    parameter  int WORDS = 8,
    parameter  int DW    = 32,
    localparam int IW    = $clog2(WORDS),
    localparam int EW    = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_ue,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          rd_ue
);

    logic [WORDS*EW-1:0] flat;

    for (genvar g = 0; g < WORDS; g++) begin : g_ent
        logic [EW-1:0] ent_d;
        logic [EW-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IW'(g))) ent_d = {wr_ue, wr_data};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign flat[g*EW +: EW] = ent_q;
    end

    assign {rd_ue, rd_data} = flat[rd_idx*EW +: EW];

endmodule

// File: rtl/evw_beat_sel.sv
module evw_beat_sel #(
    parameter  int AW    = 32,
    parameter  int DW    = 32,
    parameter  int WORDS = 8,
    localparam int IW    = $clog2(WORDS),
    localparam int SW    = DW / 8,
    localparam int BO    = $clog2(SW)
) (
    input  logic          sel_line,
    input  logic [AW-1:0] wt_addr,
    input  logic [DW-1:0] wt_data,
    input  logic [SW-1:0] wt_strb,
    input  logic [AW-1:0] line_addr,
    input  logic [IW-1:0] beat,
    input  logic [DW-1:0] line_data,
    input  logic          line_ue,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    output logic [SW-1:0] out_strb,
    output logic          out_last
);

    always_comb begin
        if (sel_line) begin
            out_addr = line_addr | (AW'(beat) << BO);
            out_data = line_data;
            out_strb = line_ue ? '0 : '1;
            out_last = (beat == IW'(WORDS - 1));
        end else begin
            out_addr = wt_addr;
            out_data = wt_data;
            out_strb = wt_strb;
            out_last = 1'b1;
        end
    end

endmodule

// File: rtl/evict_writer.sv
module evict_writer
    import evw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  parity_mode,
    input  logic                  ce_abort_en,
    input  logic                  ev_req,
    input  logic [ADDR_W-1:0]     ev_addr,
    input  logic                  ev_tag_ue,
    input  logic                  ev_dirty_ue,
    input  logic                  wd_valid,
    input  logic [EVW_DW-1:0]     wd_data,
    input  logic [EVW_CW-1:0]     wd_ecc,
    input  logic                  wt_valid,
    output logic                  wt_ready,
    input  logic [ADDR_W-1:0]     wt_addr,
    input  logic [EVW_DW-1:0]     wt_data,
    input  logic [EVW_DW/8-1:0]   wt_strb,
    output logic                  bus_valid,
    input  logic                  bus_ready,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [EVW_DW-1:0]     bus_data,
    output logic [EVW_DW/8-1:0]   bus_strb,
    output logic                  bus_last,
    output logic                  ev_done,
    output logic                  abort_req,
    output logic [2:0]            abort_cause
);

    localparam int IW     = $clog2(LINE_WORDS);
    localparam int STRB_W = EVW_DW / 8;
    localparam int OFF_W  = IW + $clog2(STRB_W);

    typedef struct packed {
        logic                  fill_act;
        logic [IW-1:0]         fill_cnt;
        logic                  line_full;
        logic [ADDR_W-1:0]     line_addr;
        logic                  meta_ue;
        logic                  data_ue;
        logic                  ce_seen;
        evw_snd_e              snd;
        logic [IW-1:0]         beat;
        logic [ADDR_W-1:0]     wt_addr;
        logic [EVW_DW-1:0]     wt_data;
        logic [STRB_W-1:0]     wt_strb;
    } evw_st_t;

    evw_st_t st_d, st_q;

    logic [EVW_DW-1:0] dec_data;
    logic              dec_ce;
    logic              dec_ue;
    logic              word_take;
    logic              ev_take;
    logic [EVW_DW-1:0] buf_data;
    logic              buf_ue;

    evw_secded_dec u_dec (
        .raw_data   (wd_data),
        .raw_chk    (wd_ecc),
        .fix_data   (dec_data),
        .corr_err   (dec_ce),
        .uncorr_err (dec_ue)
    );

    evw_line_buf #(.WORDS(LINE_WORDS), .DW(EVW_DW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (word_take),
        .wr_idx  (st_q.fill_cnt),
        .wr_data (dec_data),
        .wr_ue   (dec_ue),
        .rd_idx  (st_q.beat),
        .rd_data (buf_data),
        .rd_ue   (buf_ue)
    );

    evw_beat_sel #(.AW(ADDR_W), .DW(EVW_DW), .WORDS(LINE_WORDS)) u_sel (
        .sel_line  (st_q.snd == SND_EV),
        .wt_addr   (st_q.wt_addr),
        .wt_data   (st_q.wt_data),
        .wt_strb   (st_q.wt_strb),
        .line_addr (st_q.line_addr),
        .beat      (st_q.beat),
        .line_data (buf_data),
        .line_ue   (buf_ue),
        .out_addr  (bus_addr),
        .out_data  (bus_data),
        .out_strb  (bus_strb),
        .out_last  (bus_last)
    );

    always_comb begin
        st_d      = st_q;
        ev_take   = ev_req && !parity_mode && !st_q.fill_act && !st_q.line_full;
        word_take = wd_valid && st_q.fill_act;
        wt_ready  = (st_q.snd == SND_IDLE) && !st_q.line_full && !st_q.fill_act && !ev_take;

        // collection side
        if (ev_take) begin
            st_d.fill_act  = 1'b1;
            st_d.fill_cnt  = '0;
            st_d.line_addr = {ev_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
            st_d.meta_ue   = ev_tag_ue || ev_dirty_ue;
            st_d.data_ue   = 1'b0;
            st_d.ce_seen   = 1'b0;
        end
        if (word_take) begin
            st_d.ce_seen  = st_q.ce_seen || dec_ce;
            st_d.data_ue  = st_q.data_ue || dec_ue;
            st_d.fill_cnt = st_q.fill_cnt + 1'b1;
            if (st_q.fill_cnt == IW'(LINE_WORDS - 1)) begin
                st_d.fill_act  = 1'b0;
                st_d.line_full = 1'b1;
            end
        end

        // sending side
        unique case (st_q.snd)
            SND_IDLE: begin
                if (st_q.line_full) begin
                    st_d.snd  = st_q.meta_ue ? SND_DONE : SND_EV;
                    st_d.beat = '0;
                end else if (wt_valid && wt_ready) begin
                    st_d.snd     = SND_WT;
                    st_d.wt_addr = wt_addr;
                    st_d.wt_data = wt_data;
                    st_d.wt_strb = wt_strb;
                end
            end
            SND_WT: begin
                if (bus_ready) st_d.snd = SND_IDLE;
            end
            SND_EV: begin
                if (bus_ready) begin
                    if (st_q.beat == IW'(LINE_WORDS - 1)) st_d.snd = SND_DONE;
                    else                                   st_d.beat = st_q.beat + 1'b1;
                end
            end
            SND_DONE: begin
                st_d.line_full = 1'b0;
                st_d.snd       = SND_IDLE;
            end
            default: st_d.snd = SND_IDLE;
        endcase

        bus_valid   = (st_q.snd == SND_WT) || (st_q.snd == SND_EV);
        ev_done     = (st_q.snd == SND_DONE);
        abort_req   = ev_done && (st_q.meta_ue || st_q.data_ue || (st_q.ce_seen && ce_abort_en));
        abort_cause = ev_done ? {st_q.ce_seen, st_q.data_ue, st_q.meta_ue} : 3'b000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: stalled beat is held unchanged
    a_r6_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data)
                                   && $stable(bus_strb) && $stable(bus_last));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> !ev_done);

    // R8: abort only together with completion
    a_r8_abort_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> ev_done);

    // R4: a cancelled line never reaches the burst state
    a_r4_cancel_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.line_full && st_q.meta_ue |-> st_q.snd != SND_EV);

    // R3: eviction beats carry all strobes or none
    a_r3_strb_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.snd == SND_EV |-> (bus_strb == '1) || (bus_strb == '0));

    // R5: parity mode never starts collection
    a_r5_no_fill_in_parity: assert property (@(posedge clk) disable iff (!rst_n)
        parity_mode && !st_q.fill_act |=> !st_q.fill_act);

    // R7: store acceptance never overlaps a beat on the bus
    a_r7_wt_excl: assert property (@(posedge clk) disable iff (!rst_n)
        wt_ready |-> !bus_valid);

    // R2: decoder never flags both error classes for one word
    a_r2_dec_excl: assert property (@(posedge clk) disable iff (!rst_n)
        word_take |-> !(dec_ce && dec_ue));

endmodule

// File: tb/sim_evict_writer.sv
module sim_evict_writer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        parity_mode, ce_abort_en;
    logic        ev_req, ev_tag_ue, ev_dirty_ue;
    logic [31:0] ev_addr;
    logic        wd_valid;
    logic [31:0] wd_data;
    logic [6:0]  wd_ecc;
    logic        wt_valid, wt_ready;
    logic [31:0] wt_addr, wt_data;
    logic [3:0]  wt_strb;
    logic        bus_valid, bus_ready, bus_last;
    logic [31:0] bus_addr, bus_data;
    logic [3:0]  bus_strb;
    logic        ev_done, abort_req;
    logic [2:0]  abort_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    evict_writer u0 (
        .clk(clk), .rst_n(rst_n), .parity_mode(parity_mode), .ce_abort_en(ce_abort_en),
        .ev_req(ev_req), .ev_addr(ev_addr), .ev_tag_ue(ev_tag_ue), .ev_dirty_ue(ev_dirty_ue),
        .wd_valid(wd_valid), .wd_data(wd_data), .wd_ecc(wd_ecc),
        .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_addr(wt_addr), .wt_data(wt_data),
        .wt_strb(wt_strb), .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_strb(bus_strb), .bus_last(bus_last), .ev_done(ev_done),
        .abort_req(abort_req), .abort_cause(abort_cause)
    );

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic        last;
        string       req;
    } beat_t;

    typedef struct {
        logic       abort;
        logic [2:0] cause;
        string      req;
    } done_t;

    beat_t       exp_beats[$];
    done_t       exp_done[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          done_seen = 0;
    int          rdy_mode = 0;
    logic [7:0]  lfsr = 8'h5a;
    logic [31:0] wdat[8];
    int          wflip[8];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // code column for data bit idx: idx-th integer with two or more bits set
    function automatic logic [5:0] tb_col(input int idx);
        int seen = 0;
        for (int v = 1; v < 64; v++) begin
            if ($countones(v) >= 2) begin
                if (seen == idx) return 6'(v);
                seen++;
            end
        end
        return 6'd0;
    endfunction

    function automatic logic [6:0] tb_ecc(input logic [31:0] d);
        logic [6:0] c = '0;
        for (int k = 0; k < 6; k++) begin
            logic p = 1'b0;
            for (int i = 0; i < 32; i++) begin
                logic [5:0] col = tb_col(i);
                if (col[k]) p = p ^ d[i];
            end
            c[k] = p;
        end
        c[6] = ^{d, c[5:0]};
        return c;
    endfunction

    // ready generator
    initial begin
        bus_ready = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (rdy_mode)
                0:       bus_ready = 1'b1;
                1:       bus_ready = lfsr[0] | lfsr[2];
                default: bus_ready = 1'b0;
            endcase
        end
    end

    // monitor
    always @(negedge clk) begin
        beat_t e;
        done_t d;
        if (rst_n) begin
            if (bus_valid && bus_ready) begin
                if (exp_beats.size() == 0) begin
                    check(1'b0, "R7", "unexpected beat addr", 64'(bus_addr), 64'hdead);
                end else begin
                    e = exp_beats.pop_front();
                    check(bus_addr == e.addr, e.req, "beat addr", 64'(bus_addr), 64'(e.addr));
                    check(bus_strb == e.strb, e.req, "beat strb", 64'(bus_strb), 64'(e.strb));
                    check(bus_last == e.last, e.req, "beat last", 64'(bus_last), 64'(e.last));
                    if (e.strb != 4'h0)
                        check(bus_data == e.data, e.req, "beat data", 64'(bus_data), 64'(e.data));
                end
            end
            if (ev_done) begin
                done_seen++;
                if (exp_done.size() == 0) begin
                    check(1'b0, "R5", "unexpected done", 64'(1), 64'(0));
                end else begin
                    d = exp_done.pop_front();
                    check(abort_req == d.abort, d.req, "abort", 64'(abort_req), 64'(d.abort));
                    check(abort_cause == d.cause, d.req, "cause", 64'(abort_cause), 64'(d.cause));
                end
            end
            if (abort_req && !ev_done)
                check(1'b0, "R8", "abort without done", 64'(abort_req), 64'(0));
        end
    end

    task automatic fill_line(input int seed);
        for (int i = 0; i < 8; i++) begin
            wdat[i]  = 32'(seed) * 32'h9e3779b1 + 32'(i) * 32'h01010101;
            wflip[i] = 0;
        end
    endtask

    // flip codes: 0 clean, 1 one data bit, 2 two data bits, 3 one check bit
    task automatic evict(input logic [31:0] base, input bit tag_ue, input bit dirty_ue,
                         input string req, input bit expect_run);
        bit    any_ue = 0;
        bit    any_ce = 0;
        bit    meta = tag_ue | dirty_ue;
        beat_t b;
        done_t d;
        if (expect_run) begin
            for (int i = 0; i < 8; i++) begin
                if (wflip[i] == 2) any_ue = 1;
                if (wflip[i] == 1 || wflip[i] == 3) any_ce = 1;
                if (!meta) begin
                    b.addr = {base[31:5], 5'd0} + 32'(i * 4);
                    b.data = wdat[i];
                    b.strb = (wflip[i] == 2) ? 4'h0 : 4'hf;
                    b.last = (i == 7);
                    b.req  = req;
                    exp_beats.push_back(b);
                end
            end
            d.abort = meta | any_ue | (any_ce & ce_abort_en);
            d.cause = {any_ce, any_ue, meta};
            d.req   = req;
            exp_done.push_back(d);
        end
        @(posedge clk); #1;
        ev_req = 1'b1; ev_addr = base; ev_tag_ue = tag_ue; ev_dirty_ue = dirty_ue;
        @(posedge clk); #1;
        ev_req = 1'b0; ev_tag_ue = 1'b0; ev_dirty_ue = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] dd = wdat[i];
            logic [6:0]  cc = tb_ecc(wdat[i]);
            case (wflip[i])
                1: dd[(i * 5 + 3) % 32] = ~dd[(i * 5 + 3) % 32];
                2: begin dd[i] = ~dd[i]; dd[(i + 11) % 32] = ~dd[(i + 11) % 32]; end
                3: cc[i % 7] = ~cc[i % 7];
                default: ;
            endcase
            wd_valid = 1'b1; wd_data = dd; wd_ecc = cc;
            @(posedge clk); #1;
        end
        wd_valid = 1'b0;
    endtask

    task automatic wt_send(input logic [31:0] a, input logic [31:0] dt, input logic [3:0] s);
        beat_t b;
        @(posedge clk); #1;
        wt_valid = 1'b1; wt_addr = a; wt_data = dt; wt_strb = s;
        forever begin
            @(negedge clk);
            if (wt_ready) break;
        end
        b.addr = a; b.data = dt; b.strb = s; b.last = 1'b1; b.req = "R7";
        exp_beats.push_back(b);
        @(posedge clk); #1;
        wt_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_beats.size() != 0 || exp_done.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 64'(0), 64'(1));
        summary();
    end

    initial begin
        int done_before;
        rst_n = 1'b0; parity_mode = 1'b0; ce_abort_en = 1'b0;
        ev_req = 1'b0; ev_addr = '0; ev_tag_ue = 1'b0; ev_dirty_ue = 1'b0;
        wd_valid = 1'b0; wd_data = '0; wd_ecc = '0;
        wt_valid = 1'b0; wt_addr = '0; wt_data = '0; wt_strb = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(bus_valid == 1'b0, "R1", "reset bus_valid", 64'(bus_valid), 64'(0));
        check(ev_done == 1'b0, "R1", "reset ev_done", 64'(ev_done), 64'(0));
        check(abort_req == 1'b0, "R1", "reset abort_req", 64'(abort_req), 64'(0));
        @(posedge clk); #1; rst_n = 1'b1;

        // R1 clean line, ready always
        rdy_mode = 0; fill_line(1);
        evict(32'h0000_1000, 0, 0, "R1", 1); drain();

        // R6 clean line under random ready
        rdy_mode = 1; fill_line(2);
        evict(32'h0000_2040, 0, 0, "R6", 1); drain();

        // R2 single data-bit errors, abort masked then enabled
        fill_line(3);
        for (int i = 0; i < 8; i++) wflip[i] = 1;
        evict(32'h0000_3000, 0, 0, "R2", 1); drain();
        ce_abort_en = 1'b1; fill_line(4); wflip[5] = 1;
        evict(32'h0000_3100, 0, 0, "R2", 1); drain();
        ce_abort_en = 1'b0;

        // R9 check-bit flips on every position
        fill_line(5);
        for (int i = 0; i < 7; i++) wflip[i] = 3;
        evict(32'h0000_4000, 0, 0, "R9", 1); drain();

        // R3 two double-error words, one single error
        fill_line(6); wflip[2] = 2; wflip[5] = 2; wflip[7] = 1;
        evict(32'h0000_5000, 0, 0, "R3", 1); drain();

        // R4 tag error, then dirty error with data errors too
        fill_line(7);
        evict(32'h0000_6000, 1, 0, "R4", 1); drain();
        fill_line(8); wflip[0] = 2; wflip[3] = 1;
        evict(32'h0000_6100, 0, 1, "R4", 1); drain();

        // R5 parity mode ignores eviction
        parity_mode = 1'b1; fill_line(9); done_before = done_seen;
        evict(32'h0000_7000, 0, 0, "R5", 0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(done_seen == done_before, "R5", "done count", 64'(done_seen), 64'(done_before));
        check(bus_valid == 1'b0, "R5", "bus idle", 64'(bus_valid), 64'(0));
        parity_mode = 1'b0;

        // R7 lone write-through store
        wt_send(32'h0000_8004, 32'hcafe_f00d, 4'h6); drain();

        // R7 store and eviction offered in the same cycle: eviction first
        fill_line(10);
        fork
            evict(32'h0000_9000, 0, 0, "R7", 1);
            wt_send(32'h0000_9800, 32'h1234_5678, 4'h3);
        join
        drain();

        // R6 store stalled on the bus while an eviction fills behind it
        rdy_mode = 2;
        wt_send(32'h0000_a00c, 32'h0bad_beef, 4'hf);
        fill_line(11);
        evict(32'h0000_a100, 0, 0, "R6", 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(bus_valid == 1'b1, "R6", "stalled valid", 64'(bus_valid), 64'(1));
        check(bus_addr == 32'h0000_a00c, "R6", "stalled addr", 64'(bus_addr), 64'h0000_a00c);
        rdy_mode = 1;
        drain();

        check(exp_beats.size() == 0, "R1", "beats left", 64'(exp_beats.size()), 64'(0));
        check(exp_done.size() == 0, "R8", "dones left", 64'(exp_done.size()), 64'(0));
        summary();
    end

endmodule